// File: doc/BRIEF.md
# Video Frame Packet Sequencer

This block turns a plain stream of pixels into framed video packets on a streaming output. The output uses start-of-packet, end-of-packet, valid, ready and data signals. Each frame is sent as two packets. The first is a control packet that carries the frame width, height and interlace code. The second is a video packet: a one-beat header, then the pixel payload passed through from an upstream pixel stream. The upstream stream already holds the pixels, unpacked, in output order.

Software programs the block through a small word-addressed register slave. The slave holds two frame descriptors (width, height, interlace) and a selector register that picks the descriptor for the next frame. While the run bit is set, frames follow one another. The selector and the descriptor it picks are captured as each frame starts. Software can therefore stage the next buffer's settings, or flip the selector, at any time during the current frame without disturbing it. A frame-done status bit is set when each video packet ends. It drives an interrupt line through an enable bit and is cleared by writing one to it.

Top module: `frame_pkt_seq`

## Requirements
- R1: After reset, `vout_valid`, `pix_ready` and `frame_irq` are low, and the control, status and selector registers read as zero.
- R2: Each frame starts with a 10-beat control packet. Beat 0 carries type nibble 0xF in data bits [3:0] with `vout_sop` high. Beats 1-4 carry the 16-bit width one nibble per beat, most significant nibble first. Beats 5-8 carry the height in the same way. Beat 9 carries the interlace code with `vout_eop` high. All data bits above [3:0] are zero on these beats.
- R3: The beat after the control packet's last beat is a video packet header: type nibble 0x0 in bits [3:0], all upper data bits zero, and `vout_sop` high.
- R4: The video payload is width×height beats. Each beat carries the upstream pixel unchanged and in order, and `vout_eop` is high on the last one. When width×height is zero, the header beat itself carries `vout_eop` and no payload follows.
- R5: Frames follow one another while the run bit is set. Clearing the run bit does not cut the current frame short, but no new frame starts after it.
- R6: The frame uses the descriptor named by the selector. The selector and the descriptor are captured when the frame starts, so writes made during a frame only affect the next frame.
- R7: The frame-done status bit is set when each video packet ends. Writing 1 to status bit 0 clears it, writing 0 leaves it unchanged, and a set in the same cycle as a clear wins.
- R8: `frame_irq` is high exactly when the frame-done status bit and the interrupt enable bit are both set.
- R9: A beat offered while `vout_ready` is low stays unchanged until it is accepted. `pix_ready` is high only during the payload, and then it follows `vout_ready`.
- R10: Register map, by word address:
  - 0 is control: bit 0 is run, bit 1 is interrupt enable.
  - 1 is status: bit 0 is frame done.
  - 2 is the selector.
  - 4, 5 and 6 are descriptor 0's width, height and 4-bit interlace code.
  - 8, 9 and 10 are the same three fields of descriptor 1.
  - Every register reads back what was stored in it. Unused bits read as zero, and `cfg_rdata` is zero while `cfg_rd` is low.
- R11: A selector write with a value not below the descriptor count (2) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| cfg_addr | input | 4 | Register word address |
| cfg_rd | input | 1 | Register read strobe |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational |
| frame_irq | output | 1 | Frame-done interrupt |
| pix_data | input | 24 | Upstream pixel |
| pix_valid | input | 1 | Upstream pixel valid |
| pix_ready | output | 1 | Upstream pixel accepted when high with pix_valid |
| vout_data | output | 24 | Output stream data |
| vout_valid | output | 1 | Output beat valid |
| vout_ready | input | 1 | Downstream ready |
| vout_sop | output | 1 | Start of packet |
| vout_eop | output | 1 | End of packet |

## Verification
The hold-under-backpressure property covers payload beats. It therefore assumes that the upstream source keeps a pixel valid and unchanged until the block takes it. The bench source only drops `pix_valid` in the cycle after a pixel has been accepted. The interrupt property assumes software does not change the enable bit in the cycle that a video packet ends. The bench writes registers only when the block is idle, or partway through a control packet or payload, and never on a final beat.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
package fps_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_CTRL,
      SQ_VHDR,
      SQ_PAY
   } sq_state_t;

   localparam logic [3:0] PKT_CTRL  = 4'hF;
   localparam logic [3:0] PKT_VIDEO = 4'h0;

   // nibbles used to carry one frame dimension
   localparam int NIB_PER_DIM = 4;
   // index of the last control packet beat (type + 2 dims + interlace)
   localparam int CTRL_LAST   = 2 * NIB_PER_DIM + 1;

   localparam int RA_CTRL = 0;
   localparam int RA_STAT = 1;
   localparam int RA_SEL  = 2;
endpackage

// File: rtl/fps_regs.sv
`timescale 1ns/1ps
module fps_regs
   import fps_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int REG_W    = 32,
   parameter int DIM_W    = 16,
   parameter int NUM_DESC = 2,
   parameter int SEL_W    = 1
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic                               rd,
   input  logic                               wr,
   input  logic [REG_W-1:0]                   wdata,
   input  logic                               frame_done,
   output logic [REG_W-1:0]                   rdata,
   output logic                               run,
   output logic                               irq_en,
   output logic [SEL_W-1:0]                   sel,
   output logic [NUM_DESC-1:0][DIM_W-1:0]     dsc_w,
   output logic [NUM_DESC-1:0][DIM_W-1:0]     dsc_h,
   output logic [NUM_DESC-1:0][3:0]           dsc_il,
   output logic                               irq
);
   localparam int BANK_W = ADDR_W - 2;

   logic stat_done;
   logic wr_ctrl, wr_stat, wr_sel;
   logic unused_wbits;

   assign wr_ctrl = wr && (addr == ADDR_W'(RA_CTRL));
   assign wr_stat = wr && (addr == ADDR_W'(RA_STAT));
   assign wr_sel  = wr && (addr == ADDR_W'(RA_SEL));
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         run       <= 1'b0;
         irq_en    <= 1'b0;
         sel       <= '0;
         stat_done <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            run    <= wdata[0];
            irq_en <= wdata[1];
         end
         if (wr_sel && (wdata < REG_W'(NUM_DESC)))
            sel <= wdata[SEL_W-1:0];
         if (frame_done)
            stat_done <= 1'b1;
         else if (wr_stat && wdata[0])
            stat_done <= 1'b0;
      end
   end

   assign irq = stat_done & irq_en;

   for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
      logic [DIM_W-1:0] w_q, h_q;
      logic [3:0]       il_q;
      logic             hit;
      assign hit = wr && (addr[ADDR_W-1:2] == BANK_W'(g + 1));
      always_ff @(posedge clk or posedge rst) begin
         if (rst) begin
            w_q  <= '0;
            h_q  <= '0;
            il_q <= '0;
         end else if (hit) begin
            case (addr[1:0])
               2'd0:    w_q  <= wdata[DIM_W-1:0];
               2'd1:    h_q  <= wdata[DIM_W-1:0];
               2'd2:    il_q <= wdata[3:0];
               default: ;
            endcase
         end
      end
      assign dsc_w[g]  = w_q;
      assign dsc_h[g]  = h_q;
      assign dsc_il[g] = il_q;
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         if (addr == ADDR_W'(RA_CTRL))
            rdata[1:0] = {irq_en, run};
         else if (addr == ADDR_W'(RA_STAT))
            rdata[0] = stat_done;
         else if (addr == ADDR_W'(RA_SEL))
            rdata[SEL_W-1:0] = sel;
         else begin
            for (int i = 0; i < NUM_DESC; i++) begin
               if (addr[ADDR_W-1:2] == BANK_W'(i + 1)) begin
                  case (addr[1:0])
                     2'd0:    rdata[DIM_W-1:0] = dsc_w[i];
                     2'd1:    rdata[DIM_W-1:0] = dsc_h[i];
                     2'd2:    rdata[3:0]       = dsc_il[i];
                     default: ;
                  endcase
               end
            end
         end
      end
   end
endmodule

// File: rtl/fps_seq.sv
`timescale 1ns/1ps
module fps_seq
   import fps_pkg::*;
#(
   parameter int DATA_W   = 24,
   parameter int DIM_W    = 16,
   parameter int NUM_DESC = 2,
   parameter int SEL_W    = 1
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            run,
   input  logic [SEL_W-1:0]                sel,
   input  logic [NUM_DESC-1:0][DIM_W-1:0]  dsc_w,
   input  logic [NUM_DESC-1:0][DIM_W-1:0]  dsc_h,
   input  logic [NUM_DESC-1:0][3:0]        dsc_il,
   input  logic [DATA_W-1:0]               px_data,
   input  logic                            px_valid,
   output logic                            px_ready,
   output logic [DATA_W-1:0]               st_data,
   output logic                            st_valid,
   input  logic                            st_ready,
   output logic                            st_sop,
   output logic                            st_eop,
   output logic                            frame_done
);
   localparam int PIX_W = 2 * DIM_W;

   sq_state_t        state;
   logic [3:0]       beat;
   logic [DIM_W-1:0] cur_w, cur_h;
   logic [3:0]       cur_il;
   logic [PIX_W-1:0] left;
   logic [PIX_W-1:0] frame_px;
   logic [15:0]      w16, h16;
   logic [3:0]       nib;
   logic [DATA_W-1:0] hdr_word;
   logic             fire;

   assign frame_px = {{DIM_W{1'b0}}, dsc_w[sel]} * {{DIM_W{1'b0}}, dsc_h[sel]};

   if (DIM_W == 16) begin : g_dim_full
      assign w16 = cur_w;
      assign h16 = cur_h;
   end else begin : g_dim_pad
      assign w16 = {{(16 - DIM_W){1'b0}}, cur_w};
      assign h16 = {{(16 - DIM_W){1'b0}}, cur_h};
   end

   always_comb begin
      if (state == SQ_VHDR)
         nib = PKT_VIDEO;
      else begin
         case (beat)
            4'd0:    nib = PKT_CTRL;
            4'd1:    nib = w16[15:12];
            4'd2:    nib = w16[11:8];
            4'd3:    nib = w16[7:4];
            4'd4:    nib = w16[3:0];
            4'd5:    nib = h16[15:12];
            4'd6:    nib = h16[11:8];
            4'd7:    nib = h16[7:4];
            4'd8:    nib = h16[3:0];
            4'd9:    nib = cur_il;
            default: nib = 4'h0;
         endcase
      end
   end

   if (DATA_W == 4) begin : g_hdr_narrow
      assign hdr_word = nib;
   end else begin : g_hdr_wide
      assign hdr_word = {{(DATA_W - 4){1'b0}}, nib};
   end

   assign st_valid = (state == SQ_CTRL) || (state == SQ_VHDR) ||
                     ((state == SQ_PAY) && px_valid);
   assign st_data  = (state == SQ_PAY) ? px_data : hdr_word;
   assign st_sop   = ((state == SQ_CTRL) && (beat == 4'd0)) || (state == SQ_VHDR);
   assign st_eop   = ((state == SQ_CTRL) && (beat == 4'(CTRL_LAST))) ||
                     ((state == SQ_VHDR) && (left == '0)) ||
                     ((state == SQ_PAY)  && (left == PIX_W'(1)));
   assign px_ready = (state == SQ_PAY) && st_ready;
   assign fire     = st_valid && st_ready;
   assign frame_done = fire && st_eop && ((state == SQ_VHDR) || (state == SQ_PAY));

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state  <= SQ_IDLE;
         beat   <= '0;
         cur_w  <= '0;
         cur_h  <= '0;
         cur_il <= '0;
         left   <= '0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (run) begin
                  cur_w  <= dsc_w[sel];
                  cur_h  <= dsc_h[sel];
                  cur_il <= dsc_il[sel];
                  left   <= frame_px;
                  beat   <= '0;
                  state  <= SQ_CTRL;
               end
            end
            SQ_CTRL: begin
               if (fire) begin
                  if (beat == 4'(CTRL_LAST))
                     state <= SQ_VHDR;
                  else
                     beat <= beat + 4'd1;
               end
            end
            SQ_VHDR: begin
               if (fire)
                  state <= (left == '0) ? SQ_IDLE : SQ_PAY;
            end
            SQ_PAY: begin
               if (fire) begin
                  left <= left - PIX_W'(1);
                  if (left == PIX_W'(1))
                     state <= SQ_IDLE;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/frame_pkt_seq.sv
`timescale 1ns/1ps
module frame_pkt_seq #(
   parameter int BPS      = 8,
   parameter int PLANES   = 3,
   parameter int DIM_W    = 16,
   parameter int NUM_DESC = 2,
   parameter int ADDR_W   = 4,
   parameter int REG_W    = 32,
   localparam int DATA_W  = BPS * PLANES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_rd,
   input  logic              cfg_wr,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   output logic              frame_irq,
   input  logic [DATA_W-1:0] pix_data,
   input  logic              pix_valid,
   output logic              pix_ready,
   output logic [DATA_W-1:0] vout_data,
   output logic              vout_valid,
   input  logic              vout_ready,
   output logic              vout_sop,
   output logic              vout_eop
);
   localparam int SEL_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1;

   if (DATA_W < 4) begin : g_chk_data
      $error("frame_pkt_seq: data path narrower than a type nibble");
   end
   if (DIM_W < 1 || DIM_W > 16) begin : g_chk_dim
      $error("frame_pkt_seq: DIM_W must be 1..16");
   end
   if (NUM_DESC < 1 || NUM_DESC + 1 > (1 << (ADDR_W - 2))) begin : g_chk_desc
      $error("frame_pkt_seq: descriptor count does not fit the address map");
   end
   if (REG_W < DIM_W || REG_W < SEL_W || REG_W < 4) begin : g_chk_reg
      $error("frame_pkt_seq: register width too small");
   end

   logic                           ctl_run, ctl_irq_en, seq_done;
   logic [SEL_W-1:0]               ctl_sel;
   logic [NUM_DESC-1:0][DIM_W-1:0] d_w, d_h;
   logic [NUM_DESC-1:0][3:0]       d_il;

   fps_regs #(
      .ADDR_W(ADDR_W), .REG_W(REG_W), .DIM_W(DIM_W),
      .NUM_DESC(NUM_DESC), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst(rst),
      .addr(cfg_addr), .rd(cfg_rd), .wr(cfg_wr), .wdata(cfg_wdata),
      .frame_done(seq_done), .rdata(cfg_rdata),
      .run(ctl_run), .irq_en(ctl_irq_en), .sel(ctl_sel),
      .dsc_w(d_w), .dsc_h(d_h), .dsc_il(d_il), .irq(frame_irq)
   );

   fps_seq #(
      .DATA_W(DATA_W), .DIM_W(DIM_W), .NUM_DESC(NUM_DESC), .SEL_W(SEL_W)
   ) u_seq (
      .clk(clk), .rst(rst), .run(ctl_run), .sel(ctl_sel),
      .dsc_w(d_w), .dsc_h(d_h), .dsc_il(d_il),
      .px_data(pix_data), .px_valid(pix_valid), .px_ready(pix_ready),
      .st_data(vout_data), .st_valid(vout_valid), .st_ready(vout_ready),
      .st_sop(vout_sop), .st_eop(vout_eop), .frame_done(seq_done)
   );
endmodule

// File: rtl/fps_chk.sv
`timescale 1ns/1ps
module fps_chk #(
   parameter int DATA_W = 24
) (
   input logic              clk,
   input logic              rst,
   input logic              st_valid,
   input logic              st_ready,
   input logic              st_sop,
   input logic              st_eop,
   input logic [DATA_W-1:0] st_data,
   input logic              px_valid,
   input logic              px_ready,
   input logic [DATA_W-1:0] px_data,
   input logic              irq,
   input logic              irq_en,
   input logic              s_write
);
   logic in_video, expect_vhdr, fire, vid_eop, ctl_eop;

   assign fire    = st_valid && st_ready;
   assign vid_eop = fire && st_eop && (st_sop ? (st_data[3:0] == 4'h0) : in_video);
   assign ctl_eop = fire && st_eop && !st_sop && !in_video;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         in_video    <= 1'b0;
         expect_vhdr <= 1'b0;
      end else if (fire) begin
         if (st_sop) in_video <= (st_data[3:0] == 4'h0);
         expect_vhdr <= ctl_eop;
      end
   end

   // R9
   hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
      st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_sop) && $stable(st_eop));

   // R2
   sop_type_chk: assert property (@(posedge clk) disable iff (rst)
      st_valid && st_sop |-> (st_data[3:0] == 4'hF) || (st_data[3:0] == 4'h0));

   // R3
   vhdr_follow_chk: assert property (@(posedge clk) disable iff (rst)
      expect_vhdr && st_valid |-> st_sop && (st_data[3:0] == 4'h0));

   // R4
   pix_pass_chk: assert property (@(posedge clk) disable iff (rst)
      px_valid && px_ready |-> st_valid && st_ready && (st_data == px_data));

   // R4
   empty_hdr_chk: assert property (@(posedge clk) disable iff (rst)
      st_valid && st_sop && st_eop |-> (st_data[3:0] == 4'h0));

   // R8
   irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
      vid_eop && irq_en && !s_write |=> irq);
endmodule

bind frame_pkt_seq fps_chk #(.DATA_W(DATA_W)) u_fps_chk (
   .clk(clk), .rst(rst),
   .st_valid(vout_valid), .st_ready(vout_ready),
   .st_sop(vout_sop), .st_eop(vout_eop), .st_data(vout_data),
   .px_valid(pix_valid), .px_ready(pix_ready), .px_data(pix_data),
   .irq(frame_irq), .irq_en(ctl_irq_en), .s_write(cfg_wr)
);

// File: tb/frame_pkt_seq_bench.sv
`timescale 1ns/1ps
module frame_pkt_seq_bench;
   localparam int DW   = 24;
   localparam int LOGN = 1024;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [3:0]    cfg_addr = '0;
   logic          cfg_rd = 1'b0, cfg_wr = 1'b0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          frame_irq;
   logic [DW-1:0] pix_data = '0;
   logic          pix_valid = 1'b1;
   logic          pix_ready;
   logic [DW-1:0] vout_data;
   logic          vout_valid, vout_sop, vout_eop;
   logic          vout_ready = 1'b1;

   frame_pkt_seq u_frame_pkt_seq (
      .clk(clk), .rst(rst),
      .cfg_addr(cfg_addr), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_irq(frame_irq),
      .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
      .vout_data(vout_data), .vout_valid(vout_valid), .vout_ready(vout_ready),
      .vout_sop(vout_sop), .vout_eop(vout_eop)
   );

   int n_tests = 0, n_fail = 0;

   logic [DW-1:0] log_d [LOGN];
   logic          log_s [LOGN];
   logic          log_e [LOGN];
   int            log_n = 0;
   logic [DW-1:0] exp_d [LOGN];
   logic          exp_s [LOGN];
   logic          exp_e [LOGN];
   int            exp_n = 0;
   logic [DW-1:0] exp_pix = '0;

   logic       px_fire = 1'b0;
   logic       bp_en = 1'b0, gap_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   // monitor: sample accepted beats away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         px_fire = pix_valid && pix_ready;
         if (!rst && vout_valid && vout_ready && log_n < LOGN) begin
            log_d[log_n] = vout_data;
            log_s[log_n] = vout_sop;
            log_e[log_n] = vout_eop;
            log_n++;
         end
      end
   end

   // upstream source and downstream readiness
   initial begin
      forever begin
         @(posedge clk);
         #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         vout_ready = bp_en ? (lfsr[0] | lfsr[2]) : 1'b1;
         if (px_fire) pix_data = pix_data + 1'b1;
         pix_valid = (gap_en && px_fire) ? 1'b0 : 1'b1;
      end
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #2000000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      summary();
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(logic [3:0] a, logic [31:0] d);
      @(posedge clk);
      #1;
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(posedge clk);
      #1;
      cfg_wr = 1'b0;
   endtask

   task automatic reg_rd(logic [3:0] a, output logic [31:0] d);
      @(posedge clk);
      #1;
      cfg_addr = a; cfg_rd = 1'b1;
      @(negedge clk);
      d = cfg_rdata;
      cfg_rd = 1'b0;
   endtask

   task automatic push_exp(logic [DW-1:0] d, logic s, logic e);
      exp_d[exp_n] = d; exp_s[exp_n] = s; exp_e[exp_n] = e;
      exp_n++;
   endtask

   task automatic add_frame(logic [15:0] w, logic [15:0] h, logic [3:0] il);
      int npx;
      npx = int'(w) * int'(h);
      push_exp(DW'(4'hF), 1'b1, 1'b0);
      for (int k = 3; k >= 0; k--) push_exp(DW'(w[4*k +: 4]), 1'b0, 1'b0);
      for (int k = 3; k >= 0; k--) push_exp(DW'(h[4*k +: 4]), 1'b0, 1'b0);
      push_exp(DW'(il), 1'b0, 1'b1);
      push_exp(DW'(4'h0), 1'b1, npx == 0);
      for (int k = 0; k < npx; k++) begin
         push_exp(exp_pix, 1'b0, k == npx - 1);
         exp_pix = exp_pix + 1'b1;
      end
   endtask

   task automatic cmp_stream(string req);
      int bad;
      bad = -1;
      n_tests++;
      if (log_n != exp_n) begin
         n_fail++;
         $display("FAIL %s: beat count actual %0d expected %0d", req, log_n, exp_n);
      end else begin
         for (int k = 0; k < exp_n; k++)
            if (bad < 0 && (log_d[k] !== exp_d[k] || log_s[k] !== exp_s[k] || log_e[k] !== exp_e[k]))
               bad = k;
         if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s: beat %0d actual d=0x%0h s=%0b e=%0b expected d=0x%0h s=%0b e=%0b",
                     req, bad, log_d[bad], log_s[bad], log_e[bad],
                     exp_d[bad], exp_s[bad], exp_e[bad]);
         end
      end
   endtask

   task automatic clear_logs();
      log_n = 0;
      exp_n = 0;
   endtask

   task automatic wait_beats(int n);
      while (log_n < n) @(negedge clk);
   endtask

   // R1
   task automatic t_reset();
      logic [31:0] v;
      check("R1 vout_valid", 32'(vout_valid), 0);
      check("R1 pix_ready", 32'(pix_ready), 0);
      check("R1 frame_irq", 32'(frame_irq), 0);
      reg_rd(4'd0, v); check("R1 control", v, 0);
      reg_rd(4'd1, v); check("R1 status", v, 0);
      reg_rd(4'd2, v); check("R1 selector", v, 0);
   endtask

   // R10 R11
   task automatic t_regs();
      logic [31:0] v;
      reg_wr(4'd4, 32'hFFFF_0003);
      reg_wr(4'd5, 32'h0000_0002);
      reg_wr(4'd6, 32'h0000_0003);
      reg_wr(4'd8, 32'h0000_0123);
      reg_wr(4'd9, 32'h0000_0001);
      reg_wr(4'd10, 32'h0000_001A);
      reg_rd(4'd4, v);  check("R10 d0 width", v, 32'h3);
      reg_rd(4'd5, v);  check("R10 d0 height", v, 32'h2);
      reg_rd(4'd6, v);  check("R10 d0 interlace", v, 32'h3);
      reg_rd(4'd8, v);  check("R10 d1 width", v, 32'h123);
      reg_rd(4'd10, v); check("R10 d1 interlace 4-bit", v, 32'hA);
      reg_wr(4'd2, 32'h1);
      reg_rd(4'd2, v);  check("R10 selector", v, 32'h1);
      reg_wr(4'd2, 32'h2);
      reg_rd(4'd2, v);  check("R11 out-of-range selector ignored", v, 32'h1);
      reg_wr(4'd2, 32'h0);
      reg_wr(4'd0, 32'h2);
      reg_rd(4'd0, v);  check("R10 control", v, 32'h2);
      cfg_addr = 4'd4;
      #1;
      check("R10 rdata zero without read", cfg_rdata, 0);
   endtask

   // R2 R3 R4 R5 R7 R8 R9
   task automatic t_single();
      logic [31:0] v;
      clear_logs();
      add_frame(16'h3, 16'h2, 4'h3);
      reg_wr(4'd0, 32'h3);
      wait_beats(12);
      reg_wr(4'd0, 32'h2);
      repeat (60) @(posedge clk);
      @(negedge clk);
      cmp_stream("R2 R3 R4 R5 single frame");
      check("R5 stopped after frame", 32'(vout_valid), 0);
      check("R9 pix_ready idle", 32'(pix_ready), 0);
      check("R8 irq with enable", 32'(frame_irq), 1);
      reg_rd(4'd1, v); check("R7 status set", v, 1);
      reg_wr(4'd1, 32'h0);
      @(negedge clk);
      check("R7 write 0 keeps status", 32'(frame_irq), 1);
      reg_wr(4'd1, 32'h1);
      @(negedge clk);
      check("R7 write 1 clears", 32'(frame_irq), 0);
   endtask

   // R6 R9 R8 R5
   task automatic t_switch();
      logic [31:0] v;
      clear_logs();
      add_frame(16'h0123, 16'h1, 4'hA);
      add_frame(16'h3, 16'h2, 4'h3);
      bp_en = 1'b1;
      gap_en = 1'b1;
      reg_wr(4'd2, 32'h1);
      reg_wr(4'd0, 32'h1);
      wait_beats(1);
      reg_wr(4'd2, 32'h0);
      reg_wr(4'd8, 32'h0005);
      wait_beats(307);
      reg_wr(4'd0, 32'h0);
      repeat (200) @(posedge clk);
      @(negedge clk);
      bp_en = 1'b0;
      gap_en = 1'b0;
      cmp_stream("R6 R9 selector switch under backpressure");
      check("R8 no irq when disabled", 32'(frame_irq), 0);
      reg_rd(4'd1, v); check("R7 status set with irq off", v, 1);
      reg_rd(4'd8, v); check("R6 staged width stored", v, 32'h5);
      check("R5 idle after run cleared", 32'(vout_valid), 0);
      reg_wr(4'd1, 32'h1);
   endtask

   // R4 R7 R8
   task automatic t_empty();
      logic [31:0] v;
      clear_logs();
      reg_wr(4'd4, 32'h0);
      reg_wr(4'd5, 32'h5);
      reg_wr(4'd6, 32'h1);
      add_frame(16'h0, 16'h5, 4'h1);
      reg_wr(4'd0, 32'h3);
      wait_beats(1);
      reg_wr(4'd0, 32'h2);
      repeat (40) @(posedge clk);
      @(negedge clk);
      cmp_stream("R4 empty frame header carries eop");
      check("R8 irq after empty frame", 32'(frame_irq), 1);
      reg_wr(4'd1, 32'h1);
      reg_rd(4'd1, v); check("R7 cleared", v, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_regs();
      t_single();
      t_switch();
      t_empty();
      summary();
   end
endmodule